// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block steps a reconfigurable device through its life cycle after power-up or after a reprogram request. It holds the device while the program request is low, clears configuration memory, waits for the configuration stream to finish loading and then brings the device into user operation. The last part is a fixed, cycle-exact order: the global reset is pulsed, then the done flag rises, then outputs leave high impedance, and then writes to user storage are enabled.

The init-ready flag is modelled as an open-drain pin. One output says whether the pin is being pulled low. A second output gives the level the pin settles to when an external pull-up takes over. The memory array, stream parsing, integrity checks and clock choice sit outside the block. Only the state machine and the counter that times the start-up steps are here. Both step gaps are parameters, and both default to one cycle.

A low program request sampled on any clock edge sends the block back to its hold state on that edge. This takes priority over every other input, so a reprogram can interrupt any phase.

Top module: `cfg_startup_seq`

## Requirements
- R1: While `rst` is high and on the cycle after it, `init_pull_low`=1, `init_level`=0, `cfg_done`=0, `glb_rst`=1, `glb_hiz`=1, `glb_wr_hold`=1.
- R2: A low `prog_req_n` sampled on any clock edge gives the R1 output values from that edge on, for as long as it stays low. Clear-done and load-complete inputs have no effect during this time.
- R3: After a high `prog_req_n` is sampled in the hold state, `init_pull_low` stays 1 until a high `clr_done` is sampled in the clearing phase. From that edge on `init_pull_low` is 0.
- R4: `glb_rst` stays 1 through hold, clearing and loading.
- R5: `load_done` acts only in the loading phase and `clr_done` acts only in the clearing phase. Either strobe arriving at any other time leaves all outputs unchanged.
- R6: When `load_done` is sampled high at edge k of the loading phase, `glb_rst` stays 1 for exactly one more cycle (the pulse cycle) and is 0 from edge k+1.
- R7: `cfg_done` rises at edge k+1, the cycle after the pulse cycle, and stays 1 until the next program request.
- R8: `glb_hiz` falls at edge k+1+GTS_LAG, which is one cycle after `cfg_done` with the default GTS_LAG=1.
- R9: `glb_wr_hold` falls GWE_LAG cycles after `glb_hiz` falls (edge k+3 with defaults). All outputs then stay constant until the next program request.
- R10: `init_level` is always the inverse of `init_pull_low`: the pin reads high whenever it is not being pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Start-up clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req_n | input | 1 | Program request, active low |
| clr_done | input | 1 | Configuration memory clearing finished |
| load_done | input | 1 | Configuration stream fully loaded (strobe) |
| init_pull_low | output | 1 | 1 while the init-ready pin is driven low |
| init_level | output | 1 | Resolved init-ready pin level with pull-up |
| cfg_done | output | 1 | Configuration complete flag |
| glb_rst | output | 1 | Global set/reset to user flip-flops |
| glb_hiz | output | 1 | Global three-state, 1 keeps user outputs high impedance |
| glb_wr_hold | output | 1 | Global write block, 1 keeps user storage from writing |

## Verification
The bench checks the release order on exact edges after the load strobe. If the design merged the reset pulse with the done edge, `cfg_done` would rise one cycle early. If it released three-state and write enable together, `glb_wr_hold` would fall in the same cycle as `glb_hiz`. The bench sends load and clear strobes outside their phases, and a design that latched them would release init-ready or jump into start-up early. Program requests are dropped into clearing, loading and the middle of start-up. A design that finished its current step first would leave `cfg_done` or the released globals set for one cycle too many.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        SQ_HOLD   = 3'd0,
        SQ_CLEAR  = 3'd1,
        SQ_LOAD   = 3'd2,
        SQ_PULSE  = 3'd3,
        SQ_DONE   = 3'd4,
        SQ_HIZOFF = 3'd5,
        SQ_WREN   = 3'd6,
        SQ_RUN    = 3'd7
    } seq_state_t;

    typedef struct packed {
        logic init_pull;
        logic done;
        logic grst;
        logic hiz;
        logic wr_hold;
    } seq_ctl_t;

    localparam seq_ctl_t CTL_HOLD = '{init_pull: 1'b1, done: 1'b0, grst: 1'b1,
                                      hiz: 1'b1, wr_hold: 1'b1};

    function automatic seq_ctl_t ctl_of(input seq_state_t st);
        seq_ctl_t c;
        c = CTL_HOLD;
        case (st)
            SQ_HOLD, SQ_CLEAR: c = CTL_HOLD;
            SQ_LOAD, SQ_PULSE: c.init_pull = 1'b0;
            SQ_DONE: begin
                c.init_pull = 1'b0;
                c.done      = 1'b1;
                c.grst      = 1'b0;
            end
            SQ_HIZOFF: begin
                c.init_pull = 1'b0;
                c.done      = 1'b1;
                c.grst      = 1'b0;
                c.hiz       = 1'b0;
            end
            SQ_WREN, SQ_RUN: begin
                c.init_pull = 1'b0;
                c.done      = 1'b1;
                c.grst      = 1'b0;
                c.hiz       = 1'b0;
                c.wr_hold   = 1'b0;
            end
            default: c = CTL_HOLD;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cfg_seq_step_ctr.sv
module cfg_seq_step_ctr #(
    parameter int GTS_LAG = 1,
    parameter int GWE_LAG = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic hiz_due,
    output logic wren_due
);
    localparam int LAG_MAX = (GTS_LAG > GWE_LAG) ? GTS_LAG : GWE_LAG;
    localparam int CNT_W   = $clog2(LAG_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LAG_MAX);
    localparam logic [CNT_W-1:0] HIZ_HIT  = CNT_W'(GTS_LAG - 1);
    localparam logic [CNT_W-1:0] WREN_HIT = CNT_W'(GWE_LAG - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hiz_due  = (cnt == HIZ_HIT);
    assign wren_due = (cnt == WREN_HIT);
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_req_n,
    input  logic       clr_done,
    input  logic       load_done,
    input  logic       hiz_due,
    input  logic       wren_due,
    output seq_state_t state,
    output logic       step_change
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        if (!prog_req_n) begin
            nxt = SQ_HOLD;
        end else begin
            case (state)
                SQ_HOLD:   nxt = SQ_CLEAR;
                SQ_CLEAR:  if (clr_done)  nxt = SQ_LOAD;
                SQ_LOAD:   if (load_done) nxt = SQ_PULSE;
                SQ_PULSE:  nxt = SQ_DONE;
                SQ_DONE:   if (hiz_due)   nxt = SQ_HIZOFF;
                SQ_HIZOFF: if (wren_due)  nxt = SQ_WREN;
                SQ_WREN:   nxt = SQ_RUN;
                SQ_RUN:    nxt = SQ_RUN;
                default:   nxt = SQ_HOLD;
            endcase
        end
    end

    assign step_change = (nxt != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_HOLD;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/cfg_seq_outdec.sv
module cfg_seq_outdec
    import cfg_seq_pkg::*;
(
    input  seq_state_t state,
    output logic       init_pull_low,
    output logic       init_level,
    output logic       cfg_done,
    output logic       glb_rst,
    output logic       glb_hiz,
    output logic       glb_wr_hold
);
    seq_ctl_t ctl;

    always_comb begin
        ctl = ctl_of(state);
    end

    assign init_pull_low = ctl.init_pull;
    assign init_level    = ~ctl.init_pull;
    assign cfg_done      = ctl.done;
    assign glb_rst       = ctl.grst;
    assign glb_hiz       = ctl.hiz;
    assign glb_wr_hold   = ctl.wr_hold;
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
    import cfg_seq_pkg::*;
#(
    parameter int GTS_LAG = 1,
    parameter int GWE_LAG = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_req_n,
    input  logic clr_done,
    input  logic load_done,
    output logic init_pull_low,
    output logic init_level,
    output logic cfg_done,
    output logic glb_rst,
    output logic glb_hiz,
    output logic glb_wr_hold
);
    generate
        if (GTS_LAG < 1 || GWE_LAG < 1) begin : g_bad_lag
            $error("start-up lags must be at least one cycle");
        end
    endgenerate

    seq_state_t state;
    logic       step_change;
    logic       hiz_due;
    logic       wren_due;

    cfg_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .prog_req_n  (prog_req_n),
        .clr_done    (clr_done),
        .load_done   (load_done),
        .hiz_due     (hiz_due),
        .wren_due    (wren_due),
        .state       (state),
        .step_change (step_change)
    );

    cfg_seq_step_ctr #(
        .GTS_LAG (GTS_LAG),
        .GWE_LAG (GWE_LAG)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .restart  (step_change),
        .hiz_due  (hiz_due),
        .wren_due (wren_due)
    );

    cfg_seq_outdec u_dec (
        .state         (state),
        .init_pull_low (init_pull_low),
        .init_level    (init_level),
        .cfg_done      (cfg_done),
        .glb_rst       (glb_rst),
        .glb_hiz       (glb_hiz),
        .glb_wr_hold   (glb_wr_hold)
    );
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
    input logic clk,
    input logic rst,
    input logic prog_req_n,
    input logic init_pull_low,
    input logic cfg_done,
    input logic glb_rst,
    input logic glb_hiz,
    input logic glb_wr_hold
);
    AST_PROG_FORCES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !prog_req_n |=> (init_pull_low && !cfg_done && glb_rst && glb_hiz && glb_wr_hold)); // R2

    AST_DONE_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> !init_pull_low); // R3

    AST_RST_WHILE_LOADING: assert property (@(posedge clk) disable iff (rst)
        (!init_pull_low && !cfg_done) |-> glb_rst); // R4

    AST_RST_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(glb_rst) |-> cfg_done); // R6

    AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_done) |-> ($past(glb_rst) && !glb_rst && glb_hiz)); // R7

    AST_HIZ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(glb_hiz) |-> (cfg_done && $past(cfg_done) && glb_wr_hold)); // R8

    AST_WREN_AFTER_HIZ: assert property (@(posedge clk) disable iff (rst)
        $fell(glb_wr_hold) |-> (!glb_hiz && $past(!glb_hiz))); // R9
endmodule

bind cfg_startup_seq cfg_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .prog_req_n    (prog_req_n),
    .init_pull_low (init_pull_low),
    .cfg_done      (cfg_done),
    .glb_rst       (glb_rst),
    .glb_hiz       (glb_hiz),
    .glb_wr_hold   (glb_wr_hold)
);

// File: tb/tb_cfg_startup_seq.sv
`timescale 1ns/1ps
module tb_cfg_startup_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prog_req_n = 1'b0;
    logic clr_done = 1'b0;
    logic load_done = 1'b0;
    logic init_pull_low, init_level, cfg_done, glb_rst, glb_hiz, glb_wr_hold;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_startup_seq dut (
        .clk(clk), .rst(rst), .prog_req_n(prog_req_n), .clr_done(clr_done),
        .load_done(load_done), .init_pull_low(init_pull_low), .init_level(init_level),
        .cfg_done(cfg_done), .glb_rst(glb_rst), .glb_hiz(glb_hiz), .glb_wr_hold(glb_wr_hold)
    );

    // reference: phase 0 hold, 1 clearing, 2 loading, 3 start-up; since = cycles since load strobe
    int phase = 0;
    int since = 0;

    always @(posedge clk) begin
        if (rst || !prog_req_n) begin
            phase = 0;
            since = 0;
        end else begin
            case (phase)
                0: phase = 1;
                1: if (clr_done) phase = 2;
                2: if (load_done) begin phase = 3; since = 0; end
                default: if (since < 100) since = since + 1;
            endcase
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!finished) begin
            check("R3 init_pull_low", int'(init_pull_low), int'(phase < 2));
            check("R10 init_level", int'(init_level), int'(phase >= 2));
            check("R7 cfg_done", int'(cfg_done), int'(phase == 3 && since >= 1));
            check("R6 glb_rst", int'(glb_rst), int'(phase < 3 || since == 0));
            check("R8 glb_hiz", int'(glb_hiz), int'(!(phase == 3 && since >= 2)));
            check("R9 glb_wr_hold", int'(glb_wr_hold), int'(!(phase == 3 && since >= 3)));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sample;
        @(posedge clk);
        #1.5;
    endtask

    task automatic expect_hold(input string tag);
        check({tag, " pull"}, int'(init_pull_low), 1);
        check({tag, " done"}, int'(cfg_done), 0);
        check({tag, " grst"}, int'(glb_rst), 1);
        check({tag, " hiz"}, int'(glb_hiz), 1);
        check({tag, " wrhold"}, int'(glb_wr_hold), 1);
    endtask

    // drive from a negedge: release prog, clear after cw cycles, load after lw cycles
    task automatic run_config(input int cw, input int lw);
        prog_req_n = 1'b1;
        tick(1 + cw);
        clr_done = 1'b1;
        tick(1);
        clr_done = 1'b0;
        tick(lw);
        load_done = 1'b1;
        sample();                       // edge k
        check("R6 pulse grst", int'(glb_rst), 1);
        check("R6 pulse done", int'(cfg_done), 0);
        @(negedge clk);
        load_done = 1'b0;
        sample();                       // edge k+1
        check("R6 grst low", int'(glb_rst), 0);
        check("R7 done up", int'(cfg_done), 1);
        check("R8 hiz still", int'(glb_hiz), 1);
        sample();                       // edge k+2
        check("R8 hiz off", int'(glb_hiz), 0);
        check("R9 wr still held", int'(glb_wr_hold), 1);
        sample();                       // edge k+3
        check("R9 wr enabled", int'(glb_wr_hold), 0);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset with program request low
        tick(3);
        expect_hold("R1 reset");
        rst = 1'b0;
        sample();
        expect_hold("R1 after reset");
        // R2 / R5: strobes while program request held low
        @(negedge clk);
        clr_done = 1'b1;
        load_done = 1'b1;
        tick(2);
        expect_hold("R2 held low");
        clr_done = 1'b0;
        load_done = 1'b0;
        // R5: load strobe during clearing ignored
        prog_req_n = 1'b1;
        tick(2);
        load_done = 1'b1;
        tick(1);
        load_done = 1'b0;
        tick(1);
        check("R5 load in clear pull", int'(init_pull_low), 1);
        check("R5 load in clear done", int'(cfg_done), 0);
        // R3: clear done releases init
        clr_done = 1'b1;
        sample();
        check("R3 init released", int'(init_level), 1);
        @(negedge clk);
        clr_done = 1'b0;
        tick(3);
        check("R4 grst during load", int'(glb_rst), 1);
        check("R4 done during load", int'(cfg_done), 0);
        load_done = 1'b1;
        sample();
        check("R6 pulse cycle", int'(glb_rst), 1);
        @(negedge clk);
        load_done = 1'b0;
        tick(5);
        // R5: strobes in run ignored
        clr_done = 1'b1;
        load_done = 1'b1;
        tick(2);
        clr_done = 1'b0;
        load_done = 1'b0;
        tick(1);
        check("R5 run done", int'(cfg_done), 1);
        check("R5 run wr", int'(glb_wr_hold), 0);
        check("R9 run grst", int'(glb_rst), 0);
        // R2: program request in run
        prog_req_n = 1'b0;
        sample();
        expect_hold("R2 from run");
        @(negedge clk);
        run_config(0, 0);
        prog_req_n = 1'b0;
        tick(2);
        run_config(3, 4);
        // R2: program request during loading
        prog_req_n = 1'b0;
        tick(1);
        prog_req_n = 1'b1;
        tick(2);
        clr_done = 1'b1;
        tick(1);
        clr_done = 1'b0;
        tick(2);
        prog_req_n = 1'b0;
        sample();
        expect_hold("R2 from load");
        @(negedge clk);
        // R2: program request in middle of start-up
        prog_req_n = 1'b1;
        clr_done = 1'b1;
        tick(2);
        clr_done = 1'b0;
        load_done = 1'b1;
        tick(1);
        load_done = 1'b0;
        tick(1);
        prog_req_n = 1'b0;
        sample();
        expect_hold("R2 from start-up");
        @(negedge clk);
        // clear strobe held high across release
        clr_done = 1'b1;
        run_config(0, 1);
        tick(4);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule